// File: doc/BRIEF.md
# DDS Serial Control-Word Receiver

This block is the device-side front end of a direct digital synthesis generator. It receives configuration words over a three-wire serial link: a serial clock, a data line and an active-low frame-select. All three lines are brought into a faster system clock domain, where the block finds the falling edges of the serial clock. It shifts in 16-bit words, most significant bit first, and decodes each complete word into a write to one of five registers. These are a 16-bit control register, two 28-bit frequency registers and two 12-bit phase registers.

The top bits of every word select the register to write. The frequency registers take data in 14-bit pieces. When the control register's two-write bit is set, consecutive frequency writes fill the low half and then the high half. A reset bit in the control register is brought out as a flag, and it holds the accumulator-enable output low. The block has write access only. A one-cycle strobe marks each decoded word.

Top module: `dds_ctl_rx`

## Requirements
- R1: After the system reset, every register output is zero, the reset flag is low and no strobe is seen; the accumulator enable goes high within a few cycles.
- R2: A word is 16 bits, shifted in MSB first, one bit per serial-clock falling edge while the frame-select is low. Each complete word yields exactly one `word_stb_o` pulse.
- R3: If the frame-select rises before 16 bits have been received, the partial word is dropped: no register changes and no strobe is produced.
- R4: A word whose bits [15:14] are 00 is loaded in full into the control register.
- R5: Bits [15:14] = 01 address frequency register 0 and 10 address frequency register 1. A write to one leaves the other unchanged.
- R6: With control bit 13 set, the first frequency write loads bits [13:0] of the word into bits [13:0] of the register. The next frequency write loads bits [13:0] of the word into bits [27:14].
- R7: With control bit 13 clear, every frequency write loads bits [13:0] only, and bits [27:14] are kept.
- R8: Any control write resets the half-select state, so the next frequency write in two-write mode goes to the low half.
- R9: Bits [15:13] = 110 load bits [11:0] into phase register 0; bits [15:13] = 111 load them into phase register 1.
- R10: `reset_flag_o` equals control bit 8. While it is set, `acc_en_o` is low from the following cycle on. Writing 0x2000 after 0x2100 clears the flag and keeps two-write mode.
- R11: Serial-clock edges after the 16th within one frame are ignored, so one frame produces at most one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk_i | input | 1 | Serial clock; data is taken on its falling edge |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_fsync_n_i | input | 1 | Active-low frame select |
| ctrl_o | output | 16 | Control register |
| freq0_o | output | 28 | Frequency register 0 |
| freq1_o | output | 28 | Frequency register 1 |
| phase0_o | output | 12 | Phase register 0 |
| phase1_o | output | 12 | Phase register 1 |
| reset_flag_o | output | 1 | Control-register reset bit |
| acc_en_o | output | 1 | Accumulator enable, low while reset flag is set |
| word_stb_o | output | 1 | One-cycle pulse per decoded word |

## Verification
A wrong bit count or an off-by-one shift shows at once in the register outputs and the strobe count at the end of the frame. A stale half-select flag causes no visible fault when it goes wrong. It shows only on the next frequency write, which then lands in the wrong 14-bit half. For that reason the tests follow every mode change with further frequency writes and check both halves, and check the untouched registers too. Aborted and over-long frames are checked against the strobe count and the register values, which must not change.

// File: rtl/dds_ctl_pkg.sv
package dds_ctl_pkg;
  localparam int WORD_W     = 16;
  localparam int MODE_BIT   = 13;  // control: two-write frequency mode
  localparam int RST_BIT    = 8;   // control: reset flag
  localparam int PH_SEL_BIT = 13;  // phase word: selects register 1

  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_F0   = 2'b01,
    SEL_F1   = 2'b10,
    SEL_PH   = 2'b11
  } addr_e;
endpackage

// File: rtl/dds_in_sync.sv
module dds_in_sync #(
  parameter int       STAGES = 2,
  parameter int       W      = 3,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= IDLE;
          else        stg_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= IDLE;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dds_frame_shift.sv
module dds_frame_shift #(
  parameter int WORD_W = dds_ctl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              data_s,
  input  logic              fsync_n_s,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d, sh_next;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              fall;

  assign fall    = sclk_prev_q & ~sclk_s;
  assign sh_next = {sh_q[WORD_W-2:0], data_s};

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (fsync_n_s) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (fall && (cnt_q < FULL)) begin
      sh_d  = sh_next;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        vld_d  = 1'b1;
        word_d = sh_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b1;
      cnt_q       <= '0;
      sh_q        <= '0;
      word_q      <= '0;
      vld_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      cnt_q       <= cnt_d;
      sh_q        <= sh_d;
      word_q      <= word_d;
      vld_q       <= vld_d;
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;

  p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_abort_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_n_s |=> (cnt_q == '0) && !vld_q);
endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
  import dds_ctl_pkg::*;
#(
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [WORD_W-1:0]  ctrl_o,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o,
  output logic               stb_o
);
  localparam int HALF_W = FREQ_W / 2;

  addr_e             sel;
  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic [FREQ_W-1:0] freq_q [2];
  logic [FREQ_W-1:0] freq_d [2];
  logic [PHASE_W-1:0] ph_q [2];
  logic [PHASE_W-1:0] ph_d [2];
  logic              half_q, half_d;
  logic              stb_q;
  logic              two_wr;

  assign sel    = addr_e'(word_i[WORD_W-1:WORD_W-2]);
  assign two_wr = ctrl_q[MODE_BIT];

  always_comb begin
    ctrl_d = ctrl_q;
    half_d = half_q;
    for (int k = 0; k < 2; k++) begin
      freq_d[k] = freq_q[k];
      ph_d[k]   = ph_q[k];
    end
    if (vld_i) begin
      unique case (sel)
        SEL_CTRL: begin
          ctrl_d = word_i;
          half_d = 1'b0;
        end
        SEL_F0, SEL_F1: begin
          for (int k = 0; k < 2; k++) begin
            if ((k == 0) == (sel == SEL_F0)) begin
              if (two_wr && half_q)
                freq_d[k][FREQ_W-1:HALF_W] = word_i[HALF_W-1:0];
              else
                freq_d[k][HALF_W-1:0] = word_i[HALF_W-1:0];
            end
          end
          if (two_wr) half_d = ~half_q;
        end
        SEL_PH: begin
          if (word_i[PH_SEL_BIT]) ph_d[1] = word_i[PHASE_W-1:0];
          else                    ph_d[0] = word_i[PHASE_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      half_q <= 1'b0;
      stb_q  <= 1'b0;
      for (int k = 0; k < 2; k++) begin
        freq_q[k] <= '0;
        ph_q[k]   <= '0;
      end
    end else begin
      ctrl_q <= ctrl_d;
      half_q <= half_d;
      stb_q  <= vld_i;
      for (int k = 0; k < 2; k++) begin
        freq_q[k] <= freq_d[k];
        ph_q[k]   <= ph_d[k];
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign freq0_o  = freq_q[0];
  assign freq1_o  = freq_q[1];
  assign phase0_o = ph_q[0];
  assign phase1_o = ph_q[1];
  assign stb_o    = stb_q;

  p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && sel == SEL_CTRL) |=> (ctrl_q == $past(word_i)));
  p_half_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && sel == SEL_CTRL) |=> !half_q);
  p_low_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && sel == SEL_F0 && two_wr && !half_q) |=>
      (freq_q[0][HALF_W-1:0] == $past(word_i[HALF_W-1:0])) && half_q);
  p_other_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && sel == SEL_F0) |=> $stable(freq_q[1]));
endmodule

// File: rtl/dds_ctl_rx.sv
module dds_ctl_rx
  import dds_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FREQ_W      = 28,
  parameter int PHASE_W     = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_fsync_n_i,
  output logic [WORD_W-1:0]  ctrl_o,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o,
  output logic               reset_flag_o,
  output logic               acc_en_o,
  output logic               word_stb_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [2:0]        lines_s;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              acc_en_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  dds_in_sync #(.STAGES(SYNC_STAGES), .W(3), .IDLE(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({ser_clk_i, ser_data_i, ser_fsync_n_i}),
    .q_o   (lines_s)
  );

  dds_frame_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sclk_s     (lines_s[2]),
    .data_s     (lines_s[1]),
    .fsync_n_s  (lines_s[0]),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  dds_reg_bank #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .vld_i    (word_vld),
    .word_i   (word),
    .ctrl_o   (ctrl_o),
    .freq0_o  (freq0_o),
    .freq1_o  (freq1_o),
    .phase0_o (phase0_o),
    .phase1_o (phase1_o),
    .stb_o    (word_stb_o)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) acc_en_q <= 1'b0;
    else            acc_en_q <= ~ctrl_o[RST_BIT];
  end

  assign reset_flag_o = ctrl_o[RST_BIT];
  assign acc_en_o     = acc_en_q;

  p_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    reset_flag_o |=> !acc_en_o);
  p_stb_needs_frame_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    word_stb_o |-> $past(!lines_s[0], 2));
endmodule

// File: tb/tb_dds_ctl_rx.sv
module tb_dds_ctl_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sc, sd, fs;
  logic [15:0] ctrl;
  logic [27:0] f0, f1;
  logic [11:0] p0, p1;
  logic        rflag, acc_en, stb;
  int          checks = 0, fails = 0, stb_cnt = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dds_ctl_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sc), .ser_data_i(sd),
    .ser_fsync_n_i(fs), .ctrl_o(ctrl), .freq0_o(f0), .freq1_o(f1),
    .phase0_o(p0), .phase1_o(p1), .reset_flag_o(rflag),
    .acc_en_o(acc_en), .word_stb_o(stb)
  );

  always @(negedge clk) if (rst_n && stb === 1'b1) stb_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] val, input int n);
    fs = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sd = val[i];
      repeat (4) @(negedge clk);
      sc = 1'b0;
      repeat (4) @(negedge clk);
      sc = 1'b1;
    end
    repeat (4) @(negedge clk);
    fs = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (6) @(negedge clk);
    check("R1 ctrl", 32'(ctrl), 0);
    check("R1 freq0", 32'(f0), 0);
    check("R1 freq1", 32'(f1), 0);
    check("R1 phase", 32'({p1, p0}), 0);
    check("R1 flag", 32'(rflag), 0);
    check("R1 acc_en", 32'(acc_en), 1);
    check("R1 strobes", 32'(stb_cnt), 0);
  endtask

  task automatic t_control;
    send_bits(32'h2100, 16);
    check("R4 ctrl load", 32'(ctrl), 32'h2100);
    check("R2 one strobe", 32'(stb_cnt), 1);
    check("R10 flag set", 32'(rflag), 1);
    check("R10 acc_en low", 32'(acc_en), 0);
  endtask

  task automatic t_two_write;
    send_bits(32'h69f1, 16);
    check("R6 low half", 32'(f0), 32'h29f1);
    send_bits(32'h4123, 16);
    check("R6 high half", 32'(f0), 32'({14'h0123, 14'h29f1}));
    send_bits(32'h8005, 16);
    send_bits(32'h8007, 16);
    check("R5 freq1", 32'(f1), 32'({14'd7, 14'd5}));
    check("R5 freq0 kept", 32'(f0), 32'({14'h0123, 14'h29f1}));
    check("R2 strobes", 32'(stb_cnt), 5);
  endtask

  task automatic t_clear_reset;
    send_bits(32'h2000, 16);
    check("R10 flag clear", 32'(rflag), 0);
    check("R10 mode kept", 32'(ctrl), 32'h2000);
    check("R10 acc_en high", 32'(acc_en), 1);
  endtask

  task automatic t_half_clear;
    send_bits(32'h4011, 16);
    check("R8 first low", 32'(f0), 32'({14'h0123, 14'h0011}));
    send_bits(32'h2000, 16);
    send_bits(32'h4022, 16);
    check("R8 low again", 32'(f0), 32'({14'h0123, 14'h0022}));
  endtask

  task automatic t_single;
    send_bits(32'h1234, 16);
    check("R4 ctrl msb first", 32'(ctrl), 32'h1234);
    send_bits(32'h4555, 16);
    check("R7 low only", 32'(f0), 32'({14'h0123, 14'h0555}));
    send_bits(32'h4666, 16);
    check("R7 low again", 32'(f0), 32'({14'h0123, 14'h0666}));
  endtask

  task automatic t_phase;
    send_bits(32'hC234, 16);
    check("R9 phase0", 32'(p0), 32'h234);
    send_bits(32'hE9AB, 16);
    check("R9 phase1", 32'(p1), 32'h9AB);
    check("R9 phase0 kept", 32'(p0), 32'h234);
    check("R2 strobes", 32'(stb_cnt), 14);
  endtask

  task automatic t_partial;
    send_bits(32'h0000_03FF, 10);
    check("R3 ctrl kept", 32'(ctrl), 32'h1234);
    check("R3 no strobe", 32'(stb_cnt), 14);
  endtask

  task automatic t_extra;
    send_bits({12'h0, 16'h2100, 4'hF}, 20);
    check("R11 first 16 bits", 32'(ctrl), 32'h2100);
    check("R11 one strobe", 32'(stb_cnt), 15);
  endtask

  initial begin
    rst_n = 1'b0; sc = 1'b1; sd = 1'b0; fs = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_control();
    t_two_write();
    t_clear_reset();
    t_half_clear();
    t_single();
    t_phase();
    t_partial();
    t_extra();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule